// File: doc/BRIEF.md
# Data-Side Memory Target Router

This block sits on the data port of a processor's level-one memory system and decides, for each load or store, which memory serves it. Six targets are possible: two data tightly coupled memories, two instruction tightly coupled memories, the data cache, and the level-two bus. Each request is presented with its address, direction and three attributes (cacheable, shareable, write-through). Each of the four regions has its own base, size and enable setting. A cache-enable flag and a hit from an external tag lookup complete the inputs. The router returns a one-hot target select, a linefill request, a one-hot write-through forward destination, and a ready signal.

Routing is combinational from the request. Accesses that land in an instruction memory through the data port are slowed on purpose. A three-state pacer (`PS_IDLE`, `PS_WAIT`, `PS_GRANT`) holds ready low for a programmed number of cycles. Its transitions are as follows. `PS_IDLE` goes to `PS_WAIT` when a valid request selects an instruction memory, and loads the down-counter. `PS_WAIT` goes back to `PS_IDLE` if valid drops, goes to `PS_GRANT` when the counter reaches one, and otherwise counts down. `PS_GRANT` always returns to `PS_IDLE`. Every beat of a back-to-back burst therefore pays the full delay. The requester must hold the request stable until ready.

Top module: `dside_router`

## Requirements
- R1: Region i hits when its enable bit is 1 and the address equals its base in every bit at or above position `cfg_rgn_szlog[i]`, so the region size is 2^szlog and the base is aligned to it. Region order is 0 = data memory 0, 1 = data memory 1, 2 = instruction memory 0, 3 = instruction memory 1.
- R2: `tgt_sel` uses bit 0 for data memory 0, bit 1 for data memory 1, bit 2 for instruction memory 0, bit 3 for instruction memory 1, bit 4 for the data cache and bit 5 for level two. `wt_fwd_sel` uses the same bit positions. While `req_valid` is 1, exactly one bit of `tgt_sel` is set. While it is 0, every output is 0, including after reset.
- R3: The selection order runs from highest to lowest as follows: data memory 0, data memory 1, data cache hit, instruction memory 0, instruction memory 1, level two.
- R4: When a data memory is selected, `linefill_req` is 0 and `wt_fwd_sel` is 0, whether or not the cache hits and whatever the write-through attribute.
- R5: The cache counts as hit only when `cache_tag_hit`, `attr_cacheable` and `cfg_cache_en` are all 1 and `attr_shareable` is 0.
- R6: On a cache-hit write with write-through set, `wt_fwd_sel` names instruction memory 0 if it hits, else instruction memory 1 if it hits, else level two. Cache-hit reads and cache-hit writes without write-through forward nothing.
- R7: When an instruction memory is selected, `linefill_req` is 0 and `wt_fwd_sel` is 0.
- R8: When nothing hits, level two is selected. `linefill_req` is 1 only for a read that is cacheable while the cache is enabled. Writes never request a linefill.
- R9: Any request that does not select an instruction memory sees `req_ready` high in its first cycle.
- R10: A request that selects an instruction memory sees `req_ready` low for D cycles and high in cycle D+1. D is the clamped wait value. Each back-to-back beat repeats the full wait.
- R11: D equals `cfg_itcm_wait` when the value is between 5 and 12. Values 0 to 4 give D = 5, and values 13 to 15 give D = 12.
- R12: If `req_valid` drops before ready, the pending wait is abandoned. The next request starts a fresh count of D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = store, 0 = load |
| attr_cacheable | input | 1 | Cacheable attribute |
| attr_shareable | input | 1 | Shareable attribute |
| attr_wthru | input | 1 | Write-through attribute |
| cfg_rgn_base | input | 128 | Four 32-bit region bases, region 0 in the low bits |
| cfg_rgn_szlog | input | 20 | Four 5-bit log2 region sizes, region 0 in the low bits |
| cfg_rgn_en | input | 4 | Region enables |
| cfg_cache_en | input | 1 | Data cache enabled |
| cache_tag_hit | input | 1 | Tag lookup hit for the current address |
| cfg_itcm_wait | input | 4 | Instruction-memory wait setting, clamped to 5..12 |
| tgt_sel | output | 6 | One-hot target select |
| linefill_req | output | 1 | Start a cache linefill from level two |
| wt_fwd_sel | output | 6 | One-hot write-through forward destination |
| req_ready | output | 1 | Request completes at the next clock edge |

## Verification
Routing carries no state, so a wrong priority or hit decision shows on `tgt_sel`, `linefill_req` or `wt_fwd_sel` in the same cycle the request appears. The only internal state is the pacer state and its down-counter. A wrong value there shows up at `req_ready`: ready arrives one or more cycles early or late on an instruction-memory access, or a non-instruction access is stalled. The error is visible within at most twelve cycles of the request. An abandoned wait that leaves stale state shows as a shortened latency on the very next instruction-memory request.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int N_RGN    = 4;
    localparam int N_TGT    = 6;
    localparam int T_DTCM0  = 0;
    localparam int T_DTCM1  = 1;
    localparam int T_ITCM0  = 2;
    localparam int T_ITCM1  = 3;
    localparam int T_DCACHE = 4;
    localparam int T_L2     = 5;

    localparam logic [3:0] WAIT_MIN = 4'd5;
    localparam logic [3:0] WAIT_MAX = 4'd12;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WAIT  = 2'd1,
        PS_GRANT = 2'd2
    } pace_state_e;

    function automatic logic [3:0] clamp_wait(input logic [3:0] w);
        if (w < WAIT_MIN) return WAIT_MIN;
        if (w > WAIT_MAX) return WAIT_MAX;
        return w;
    endfunction
endpackage

// File: rtl/dsr_region_match.sv
module dsr_region_match #(
    parameter int AW = 32,
    parameter int SW = 5
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] szlog,
    input  logic          en,
    output logic          hit
);
    logic [AW-1:0] keep_mask;

    // Bits at or above szlog must match; lower bits are the offset.
    assign keep_mask = {AW{1'b1}} << szlog;
    assign hit       = en && ((addr & keep_mask) == (base & keep_mask));
endmodule

// File: rtl/dsr_route_decide.sv
module dsr_route_decide
    import dsr_pkg::*;
(
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             attr_cacheable,
    input  logic             attr_shareable,
    input  logic             attr_wthru,
    input  logic             cfg_cache_en,
    input  logic             cache_tag_hit,
    input  logic [N_RGN-1:0] rgn_hit,
    output logic [N_TGT-1:0] tgt_sel,
    output logic             linefill_req,
    output logic [N_TGT-1:0] wt_fwd_sel,
    output logic             itcm_primary
);
    logic cache_hit;

    assign cache_hit = cache_tag_hit && attr_cacheable && !attr_shareable && cfg_cache_en;

    always_comb begin
        tgt_sel      = '0;
        wt_fwd_sel   = '0;
        linefill_req = 1'b0;
        if (req_valid) begin
            if (rgn_hit[T_DTCM0]) begin
                tgt_sel[T_DTCM0] = 1'b1;
            end else if (rgn_hit[T_DTCM1]) begin
                tgt_sel[T_DTCM1] = 1'b1;
            end else if (cache_hit) begin
                tgt_sel[T_DCACHE] = 1'b1;
                if (req_write && attr_wthru) begin
                    if (rgn_hit[T_ITCM0])      wt_fwd_sel[T_ITCM0] = 1'b1;
                    else if (rgn_hit[T_ITCM1]) wt_fwd_sel[T_ITCM1] = 1'b1;
                    else                       wt_fwd_sel[T_L2]    = 1'b1;
                end
            end else if (rgn_hit[T_ITCM0]) begin
                tgt_sel[T_ITCM0] = 1'b1;
            end else if (rgn_hit[T_ITCM1]) begin
                tgt_sel[T_ITCM1] = 1'b1;
            end else begin
                tgt_sel[T_L2] = 1'b1;
                linefill_req  = !req_write && attr_cacheable && cfg_cache_en;
            end
        end
    end

    assign itcm_primary = tgt_sel[T_ITCM0] || tgt_sel[T_ITCM1];
endmodule

// File: rtl/dsr_itcm_pacer.sv
module dsr_itcm_pacer
    import dsr_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          itcm_primary,
    input  logic [3:0]    cfg_itcm_wait,
    output logic          req_ready
);
    pace_state_e   st, st_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [3:0]    wait_eff;

    assign wait_eff = clamp_wait(cfg_itcm_wait);

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            PS_IDLE: begin
                if (req_valid && itcm_primary) begin
                    st_nxt  = PS_WAIT;
                    cnt_nxt = CW'(wait_eff - 4'd1);
                end
            end
            PS_WAIT: begin
                if (!req_valid)          st_nxt  = PS_IDLE;
                else if (cnt == CW'(1))  st_nxt  = PS_GRANT;
                else                     cnt_nxt = cnt - CW'(1);
            end
            PS_GRANT: st_nxt = PS_IDLE;
            default:  st_nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PS_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        unique case (st)
            PS_IDLE:  req_ready = req_valid && !itcm_primary;
            PS_WAIT:  req_ready = 1'b0;
            PS_GRANT: req_ready = req_valid;
            default:  req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/dside_router.sv
module dside_router
    import dsr_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [AW-1:0]       req_addr,
    input  logic                req_write,
    input  logic                attr_cacheable,
    input  logic                attr_shareable,
    input  logic                attr_wthru,
    input  logic [4*AW-1:0]     cfg_rgn_base,
    input  logic [4*SW-1:0]     cfg_rgn_szlog,
    input  logic [3:0]          cfg_rgn_en,
    input  logic                cfg_cache_en,
    input  logic                cache_tag_hit,
    input  logic [3:0]          cfg_itcm_wait,
    output logic [5:0]          tgt_sel,
    output logic                linefill_req,
    output logic [5:0]          wt_fwd_sel,
    output logic                req_ready
);
    logic [N_RGN-1:0] rgn_hit;
    logic             itcm_primary;

    for (genvar i = 0; i < N_RGN; i++) begin : g_rgn
        dsr_region_match #(.AW(AW), .SW(SW)) u_match (
            .addr  (req_addr),
            .base  (cfg_rgn_base[i*AW +: AW]),
            .szlog (cfg_rgn_szlog[i*SW +: SW]),
            .en    (cfg_rgn_en[i]),
            .hit   (rgn_hit[i])
        );
    end

    dsr_route_decide u_decide (
        .req_valid      (req_valid),
        .req_write      (req_write),
        .attr_cacheable (attr_cacheable),
        .attr_shareable (attr_shareable),
        .attr_wthru     (attr_wthru),
        .cfg_cache_en   (cfg_cache_en),
        .cache_tag_hit  (cache_tag_hit),
        .rgn_hit        (rgn_hit),
        .tgt_sel        (tgt_sel),
        .linefill_req   (linefill_req),
        .wt_fwd_sel     (wt_fwd_sel),
        .itcm_primary   (itcm_primary)
    );

    dsr_itcm_pacer #(.CW(4)) u_pacer (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .itcm_primary  (itcm_primary),
        .cfg_itcm_wait (cfg_itcm_wait),
        .req_ready     (req_ready)
    );
endmodule

// File: rtl/dside_router_chk.sv
module dside_router_chk
    import dsr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic       attr_shareable,
    input logic [3:0] cfg_itcm_wait,
    input logic [5:0] tgt_sel,
    input logic       linefill_req,
    input logic [5:0] wt_fwd_sel,
    input logic       req_ready
);
    logic       itcm_sel;
    logic [4:0] wait_cnt;

    assign itcm_sel = tgt_sel[T_ITCM0] || tgt_sel[T_ITCM1];

    // Cycles spent so far on the current instruction-memory request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  wait_cnt <= '0;
        else if (req_valid && itcm_sel && !req_ready) wait_cnt <= (wait_cnt == 5'd31) ? wait_cnt : wait_cnt + 5'd1;
        else                                         wait_cnt <= '0;
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones(tgt_sel) == 1);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (tgt_sel == 6'd0 && !linefill_req && wt_fwd_sel == 6'd0 && !req_ready));

    a_r4_dtcm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel[T_DTCM0] || tgt_sel[T_DTCM1]) |-> (!linefill_req && wt_fwd_sel == 6'd0));

    a_r5_shared_no_cache: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && attr_shareable) |-> !tgt_sel[T_DCACHE]);

    a_r6_fwd_cache_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_fwd_sel != 6'd0) |-> (tgt_sel[T_DCACHE] && req_write && $onehot0(wt_fwd_sel)));

    a_r7_itcm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        itcm_sel |-> (!linefill_req && wt_fwd_sel == 6'd0));

    a_r8_linefill_read_l2: assert property (@(posedge clk) disable iff (!rst_n)
        linefill_req |-> (tgt_sel[T_L2] && !req_write));

    a_r9_fast_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !itcm_sel) |-> req_ready);

    a_r10_itcm_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && itcm_sel && req_ready) |-> (wait_cnt == {1'b0, clamp_wait(cfg_itcm_wait)}));
endmodule

bind dside_router dside_router_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .attr_shareable (attr_shareable),
    .cfg_itcm_wait  (cfg_itcm_wait),
    .tgt_sel        (tgt_sel),
    .linefill_req   (linefill_req),
    .wt_fwd_sel     (wt_fwd_sel),
    .req_ready      (req_ready)
);

// File: tb/dside_router_tb.sv
`timescale 1ns/1ps
module dside_router_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_write = 1'b0;
    logic         attr_cacheable = 1'b0;
    logic         attr_shareable = 1'b0;
    logic         attr_wthru = 1'b0;
    logic [127:0] cfg_rgn_base;
    logic [19:0]  cfg_rgn_szlog;
    logic [3:0]   cfg_rgn_en = 4'hF;
    logic         cfg_cache_en = 1'b1;
    logic         cache_tag_hit = 1'b0;
    logic [3:0]   cfg_itcm_wait = 4'd7;
    logic [5:0]   tgt_sel;
    logic         linefill_req;
    logic [5:0]   wt_fwd_sel;
    logic         req_ready;

    logic [31:0]  c_base [4];
    logic [4:0]   c_sz   [4];

    assign cfg_rgn_base  = {c_base[3], c_base[2], c_base[1], c_base[0]};
    assign cfg_rgn_szlog = {c_sz[3], c_sz[2], c_sz[1], c_sz[0]};

    always #2 clk = ~clk;

    dside_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .attr_cacheable(attr_cacheable),
        .attr_shareable(attr_shareable), .attr_wthru(attr_wthru),
        .cfg_rgn_base(cfg_rgn_base), .cfg_rgn_szlog(cfg_rgn_szlog),
        .cfg_rgn_en(cfg_rgn_en), .cfg_cache_en(cfg_cache_en),
        .cache_tag_hit(cache_tag_hit), .cfg_itcm_wait(cfg_itcm_wait),
        .tgt_sel(tgt_sel), .linefill_req(linefill_req),
        .wt_fwd_sel(wt_fwd_sel), .req_ready(req_ready)
    );

    typedef struct {
        logic [5:0] sel;
        logic       lf;
        logic [5:0] fwd;
        int         lat;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_done   = 0;
    int   cyc      = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wait_of(input logic [3:0] w);
        if (w < 4'd5) return 5;
        if (w > 4'd12) return 12;
        return int'(w);
    endfunction

    // Requirement model R1..R11, driven by the bench's own copy of the config.
    function automatic exp_t model(input logic [31:0] a, input bit wr, input bit c,
                                   input bit s, input bit wt, input bit th, input string tag);
        exp_t e;
        bit   h [4];
        bit   ch;
        e.sel = '0; e.lf = 1'b0; e.fwd = '0; e.lat = 1; e.tag = tag;
        for (int i = 0; i < 4; i++)
            h[i] = cfg_rgn_en[i] && (((a ^ c_base[i]) >> c_sz[i]) == 32'd0);
        ch = th && c && !s && cfg_cache_en;
        if (h[0])      e.sel = 6'b000001;
        else if (h[1]) e.sel = 6'b000010;
        else if (ch) begin
            e.sel = 6'b010000;
            if (wr && wt) e.fwd = h[2] ? 6'b000100 : (h[3] ? 6'b001000 : 6'b100000);
        end else if (h[2]) begin e.sel = 6'b000100; e.lat = wait_of(cfg_itcm_wait) + 1; end
        else if (h[3]) begin e.sel = 6'b001000; e.lat = wait_of(cfg_itcm_wait) + 1; end
        else begin
            e.sel = 6'b100000;
            e.lf  = !wr && c && cfg_cache_en;
        end
        return e;
    endfunction

    // Driver: presents one beat, records the expectation, waits for completion.
    task automatic issue(input logic [31:0] a, input bit wr, input bit c, input bit s,
                         input bit wt, input bit th, input string tag);
        int target;
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_write = wr;
        attr_cacheable = c; attr_shareable = s; attr_wthru = wt; cache_tag_hit = th;
        q.push_back(model(a, wr, c, s, wt, th, tag));
        target = n_done + 1;
        wait (n_done >= target);
    endtask

    task automatic go_idle(input int n);
        @(posedge clk); #1;
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    // Monitor: compares at the falling edge of the cycle in which ready shows.
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            cyc++;
            if (req_ready) begin
                if (q.size() == 0) begin
                    chk("R2", "unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.tag, "tgt_sel", tgt_sel, e.sel);
                    chk(e.tag, "linefill_req", linefill_req, e.lf);
                    chk(e.tag, "wt_fwd_sel", wt_fwd_sel, e.fwd);
                    chk(e.tag, "latency", cyc, e.lat);
                end
                cyc = 0;
                n_done++;
            end
        end else begin
            cyc = 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        c_base[0] = 32'h1000_0000; c_sz[0] = 5'd12;
        c_base[1] = 32'h1000_0000; c_sz[1] = 5'd14;
        c_base[2] = 32'h2000_0000; c_sz[2] = 5'd13;
        c_base[3] = 32'h2000_0000; c_sz[3] = 5'd16;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", "reset tgt_sel", tgt_sel, 0);
        chk("R2", "reset ready", req_ready, 0);
        chk("R2", "reset linefill", linefill_req, 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R3 R4: overlapping data memories, data memory wins over cache
        issue(32'h1000_0010, 0, 1, 0, 0, 1, "R3");
        issue(32'h1000_0010, 1, 1, 0, 1, 1, "R4");
        // R1: size boundaries
        issue(32'h1000_0FFF, 0, 0, 0, 0, 0, "R1");
        issue(32'h1000_1000, 0, 0, 0, 0, 0, "R1");
        issue(32'h1000_3FFF, 1, 0, 0, 0, 0, "R1");
        issue(32'h1000_4000, 0, 0, 0, 0, 0, "R1");
        // R5 R6: cache hits
        issue(32'h3000_0000, 0, 1, 0, 0, 1, "R5");
        issue(32'h3000_0040, 1, 1, 0, 1, 1, "R6");
        issue(32'h3000_0040, 1, 1, 0, 0, 1, "R6");
        issue(32'h3000_0080, 0, 1, 1, 0, 1, "R5");
        issue(32'h3000_0080, 0, 0, 0, 0, 1, "R5");
        // R6: cache hit over instruction memories forwards there
        issue(32'h2000_0100, 1, 1, 0, 1, 1, "R6");
        issue(32'h2000_4000, 1, 1, 0, 1, 1, "R6");
        issue(32'h2000_0100, 0, 1, 0, 1, 1, "R6");
        // R7 R10: instruction memories through the data port
        issue(32'h2000_0100, 0, 1, 0, 0, 0, "R7");
        issue(32'h2000_4000, 1, 1, 0, 1, 0, "R7");
        // R10: back-to-back beats each pay the wait
        issue(32'h2000_0200, 0, 0, 0, 0, 0, "R10");
        issue(32'h2000_0204, 0, 0, 0, 0, 0, "R10");
        issue(32'h2000_0208, 0, 0, 0, 0, 0, "R10");
        // R8: total miss
        issue(32'h3000_1000, 0, 1, 0, 0, 0, "R8");
        issue(32'h3000_1000, 0, 0, 0, 0, 0, "R8");
        issue(32'h3000_1000, 1, 1, 0, 1, 0, "R8");
        go_idle(1);
        cfg_cache_en = 1'b0;
        issue(32'h3000_1000, 0, 1, 0, 0, 1, "R8");
        go_idle(1);
        cfg_cache_en = 1'b1;

        // R11: clamping of the wait setting
        cfg_itcm_wait = 4'd0;  issue(32'h2000_0000, 0, 0, 0, 0, 0, "R11"); go_idle(1);
        cfg_itcm_wait = 4'd4;  issue(32'h2000_0000, 0, 0, 0, 0, 0, "R11"); go_idle(1);
        cfg_itcm_wait = 4'd5;  issue(32'h2000_0000, 0, 0, 0, 0, 0, "R11"); go_idle(1);
        cfg_itcm_wait = 4'd12; issue(32'h2000_0000, 0, 0, 0, 0, 0, "R11"); go_idle(1);
        cfg_itcm_wait = 4'd15; issue(32'h2000_0000, 0, 0, 0, 0, 0, "R11"); go_idle(1);
        cfg_itcm_wait = 4'd9;

        // R12: abandon a wait, then a fresh request pays the full count
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = 32'h2000_0010; req_write = 1'b0;
        attr_cacheable = 1'b0; attr_shareable = 1'b0; attr_wthru = 1'b0; cache_tag_hit = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R12", "ready during wait", req_ready, 0);
        end
        @(posedge clk); #1; req_valid = 1'b0;
        @(negedge clk);
        chk("R12", "ready after drop", req_ready, 0);
        issue(32'h2000_0010, 0, 0, 0, 0, 0, "R12");
        go_idle(1);

        // R1: a disabled region is skipped
        cfg_rgn_en = 4'b1110;
        issue(32'h1000_0010, 0, 0, 0, 0, 0, "R1");
        go_idle(1);
        cfg_rgn_en = 4'hF;

        // R3: all four regions overlapping
        c_base[2] = 32'h1000_0000; c_sz[2] = 5'd15;
        c_base[3] = 32'h1000_0000; c_sz[3] = 5'd28;
        issue(32'h1000_0010, 0, 0, 0, 0, 0, "R3");
        issue(32'h1000_2000, 0, 0, 0, 0, 0, "R3");
        issue(32'h1000_5000, 0, 0, 0, 0, 0, "R3");
        issue(32'h1001_0000, 1, 0, 0, 0, 0, "R3");
        go_idle(2);

        @(negedge clk);
        chk("R2", "idle tgt_sel", tgt_sel, 0);
        chk("R2", "queue drained", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule